// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether an incoming destination MAC address belongs to a multicast group that the station has joined. The address arrives one byte per cycle. As each byte arrives, the block folds it into an Ethernet CRC-32. When the sixth byte has been absorbed, eight bits of the resulting checksum select one entry of a 256-entry membership table. The frame is accepted when that entry is set. The table is held as eight 32-bit words that software can write and read back.

The block also reports the computed index together with every decision. Software can therefore present an address and learn which table bit it must set or clear to join or leave that group. A promiscuous input overrides the table and forces acceptance. Addresses whose group bit is clear are never accepted through the table.

When a lookup starts, the lookup logic takes a private copy of the table. A register write that lands while an address is streaming in therefore only affects the next address.

Top module: `mcast_hash_filter`

## Requirements
- R1: The checksum starts at 0xFFFFFFFF. It is the reflected CRC-32 with polynomial 0xEDB88320. Each byte is consumed least significant bit first, bytes are taken in arrival order, and no final inversion is applied. The reported index is the bit-reversal of the low 8 checksum bits: index bit 7 is checksum bit 0, and index bit 0 is checksum bit 7.
- R2: A byte with `addr_first` high starts a new address, and this abandons any partial address. The five bytes that follow complete it. Bytes without `addr_first` that arrive while no address is open are ignored and produce no result.
- R3: `res_vld` is high for exactly one cycle, the cycle after the sixth byte is taken. `res_index` and `res_accept` are meaningful only in that cycle, and `res_accept` is low whenever `res_vld` is low.
- R4: Index bits [7:5] select table word `tbl_sel`. Index bits [4:0] give the entry number b, and entry b is data bit 31-b of that word. Entry 0 is therefore the MSB of word 0, and entry 255 is the LSB of word 7.
- R5: After reset all eight words read as zero, and no group address is accepted.
- R6: An address whose first byte has bit 0 clear is rejected unless promiscuous mode is on. Its index is still reported.
- R7: With `promisc` high in the result cycle, `res_accept` is high for any address.
- R8: When `tbl_wr` is high at a clock edge, the whole word `tbl_sel` is replaced by `tbl_wdata`. `tbl_rdata` shows word `tbl_sel` combinationally.
- R9: A table write issued in the same cycle as an address's first byte, or later during that address, does not change that address's decision. The write does apply to the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld | input | 1 | Address byte present this cycle |
| addr_first | input | 1 | Marks the first byte of an address |
| addr_byte | input | 8 | Address byte, first transmitted byte first |
| promisc | input | 1 | Force acceptance |
| tbl_wr | input | 1 | Table word write strobe |
| tbl_sel | input | 3 | Table word select for write and read |
| tbl_wdata | input | 32 | Table word write data |
| tbl_rdata | output | 32 | Table word read data |
| res_vld | output | 1 | Decision strobe |
| res_index | output | 8 | Hash index of the address |
| res_accept | output | 1 | Address accepted |

## Verification
The embedded assertions check on every cycle the properties that concern control and state:
- the single-cycle decision strobe;
- the bounded byte position;
- the rule that stray bytes leave the checksum untouched;
- the frozen lookup copy while no address is starting;
- the promiscuous override and the unicast rejection.

The values themselves can only be shown by the bench scenarios. These are the checksum-derived index, the MSB-first placement of entries within words, the reset-empty table, and the precise cycle at which a concurrent write becomes visible. The bench sweeps many addresses, each against a table holding only that address's entry and against the complement of that table.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   localparam logic [31:0] MHF_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] MHF_CRC_SEED  = 32'hFFFF_FFFF;

   // One byte of reflected CRC-32, least significant data bit first.
   function automatic logic [31:0] mhf_crc_byte(input logic [31:0] cur,
                                                input logic [7:0]  dat);
      logic [31:0] r;
      r = cur;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ dat[i]) r = (r >> 1) ^ MHF_POLY_REFL;
         else               r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
   import mhf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int OUT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld_i,
   input  logic             byte_first_i,
   input  logic [7:0]       byte_data_i,
   output logic             start_o,
   output logic             done_o,
   output logic             grp_o,
   output logic [OUT_W-1:0] crc_o
);

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] pos_q;
   logic [31:0]      crc_q;
   logic             grp_q;
   logic             done_q;
   logic             take;
   logic             last;
   logic [31:0]      seed;

   // A byte is taken when it opens an address or continues an open one.
   assign take = byte_vld_i && (byte_first_i || (pos_q != '0));
   assign last = take && (byte_first_i ? (ADDR_BYTES == 1) : (pos_q == LAST_POS));
   assign seed = byte_first_i ? MHF_CRC_SEED : crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         crc_q  <= MHF_CRC_SEED;
         grp_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (take) begin
            crc_q <= mhf_crc_byte(seed, byte_data_i);
            if (last)              pos_q <= '0;
            else if (byte_first_i) pos_q <= CNT_W'(1);
            else                   pos_q <= pos_q + CNT_W'(1);
            if (byte_first_i)      grp_q <= byte_data_i[0];
         end
      end
   end

   assign start_o = byte_vld_i && byte_first_i;
   assign done_o  = done_q;
   assign grp_o   = grp_q;
   assign crc_o   = crc_q[OUT_W-1:0];

   // R2: the byte position never leaves the address length
   a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < CNT_W'(ADDR_BYTES));

   // R2: a stray byte outside any address leaves the checksum alone
   a_r2_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !byte_first_i && pos_q == '0) |=> ($stable(crc_q) && !done_q));

   // R3: a completion strobe lasts one cycle
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      (ADDR_BYTES > 1 && done_q) |=> !done_q);

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 8,
   localparam int SEL_W    = $clog2(NUM_WORDS),
   localparam int BITS     = WORD_W * NUM_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o,
   input  logic              snap_i,
   output logic [BITS-1:0]   shadow_o
);

   logic [WORD_W-1:0] word_q [NUM_WORDS];
   logic [BITS-1:0]   live_flat;
   logic [BITS-1:0]   shadow_q;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              word_q[w] <= '0;
         else if (wr_i && sel_i == SEL_W'(w))     word_q[w] <= wdata_i;
      end
      assign live_flat[w*WORD_W +: WORD_W] = word_q[w];
   end

   // The lookup copy is taken from the contents before this edge's write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_q <= '0;
      else if (snap_i) shadow_q <= live_flat;
   end

   assign rdata_o  = word_q[sel_i];
   assign shadow_o = shadow_q;

   // R9: the lookup copy is frozen unless an address starts
   a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i |=> $stable(shadow_q));

endmodule

// File: rtl/mhf_lookup.sv
module mhf_lookup #(
   parameter int IDX_W  = 8,
   parameter int BIT_W  = 5,
   localparam int BITS  = 2 ** IDX_W
) (
   input  logic             done_i,
   input  logic             grp_i,
   input  logic [IDX_W-1:0] crc_i,
   input  logic [BITS-1:0]  shadow_i,
   input  logic             promisc_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] index_o,
   output logic             accept_o
);

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] pos;
   logic             entry;

   // Index is the bit-reversed low part of the checksum.
   for (genvar k = 0; k < IDX_W; k++) begin : g_rev
      assign idx[IDX_W-1-k] = crc_i[k];
   end

   // Entries are numbered MSB-first inside each word.
   assign pos   = {idx[IDX_W-1:BIT_W], ~idx[BIT_W-1:0]};
   assign entry = shadow_i[pos];

   assign vld_o    = done_i;
   assign index_o  = idx;
   assign accept_o = done_i && (promisc_i || (grp_i && entry));

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W      = 8,
   parameter int WORD_W     = 32,
   localparam int TABLE_BITS = 2 ** IDX_W,
   localparam int NUM_WORDS  = TABLE_BITS / WORD_W,
   localparam int SEL_W      = $clog2(NUM_WORDS),
   localparam int BIT_W      = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld,
   input  logic              addr_first,
   input  logic [7:0]        addr_byte,
   input  logic              promisc,
   input  logic              tbl_wr,
   input  logic [SEL_W-1:0]  tbl_sel,
   input  logic [WORD_W-1:0] tbl_wdata,
   output logic [WORD_W-1:0] tbl_rdata,
   output logic              res_vld,
   output logic [IDX_W-1:0]  res_index,
   output logic              res_accept
);

   if (IDX_W < 2 || IDX_W > 32) begin : g_bad_idx
      $error("IDX_W must lie in 2..32");
   end
   if (WORD_W != 2 ** BIT_W) begin : g_bad_word
      $error("WORD_W must be a power of two");
   end
   if (NUM_WORDS < 2 || NUM_WORDS * WORD_W != TABLE_BITS) begin : g_bad_split
      $error("table must split into at least two whole words");
   end
   if (ADDR_BYTES < 1) begin : g_bad_len
      $error("ADDR_BYTES must be positive");
   end

   logic                  start;
   logic                  done;
   logic                  grp;
   logic [IDX_W-1:0]      crc_low;
   logic [TABLE_BITS-1:0] shadow;

   mhf_crc_unit #(.ADDR_BYTES(ADDR_BYTES), .OUT_W(IDX_W)) u_crc (
      .clk          (clk),
      .rst_n        (rst_n),
      .byte_vld_i   (addr_vld),
      .byte_first_i (addr_first),
      .byte_data_i  (addr_byte),
      .start_o      (start),
      .done_o       (done),
      .grp_o        (grp),
      .crc_o        (crc_low)
   );

   mhf_table #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (tbl_wr),
      .sel_i    (tbl_sel),
      .wdata_i  (tbl_wdata),
      .rdata_o  (tbl_rdata),
      .snap_i   (start),
      .shadow_o (shadow)
   );

   mhf_lookup #(.IDX_W(IDX_W), .BIT_W(BIT_W)) u_lookup (
      .done_i    (done),
      .grp_i     (grp),
      .crc_i     (crc_low),
      .shadow_i  (shadow),
      .promisc_i (promisc),
      .vld_o     (res_vld),
      .index_o   (res_index),
      .accept_o  (res_accept)
   );

   // R3: no acceptance outside the decision strobe
   a_r3_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> !res_accept);

   // R3: a decision is always preceded by an address byte
   a_r3_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(addr_vld));

   // R7: promiscuous mode accepts every decided address
   a_r7_promisc_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && promisc) |-> res_accept);

   // R6: a unicast address is rejected without promiscuous mode
   a_r6_unicast_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !promisc && !grp) |-> !res_accept);

endmodule

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_vld = 1'b0;
   logic        addr_first = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic        promisc = 1'b0;
   logic        tbl_wr = 1'b0;
   logic [2:0]  tbl_sel = '0;
   logic [31:0] tbl_wdata = '0;
   logic [31:0] tbl_rdata;
   logic        res_vld;
   logic [7:0]  res_index;
   logic        res_accept;

   int compared = 0;
   int mismatched = 0;

   always #4 clk = ~clk;

   mcast_hash_filter i_mcast_hash_filter (
      .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_first(addr_first),
      .addr_byte(addr_byte), .promisc(promisc), .tbl_wr(tbl_wr),
      .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
      .res_vld(res_vld), .res_index(res_index), .res_accept(res_accept)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   // Expected index per R1
   function automatic logic [7:0] exp_index(input logic [47:0] a);
      logic [31:0] c;
      logic [7:0]  ix;
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < 6; k++)
         for (int i = 0; i < 8; i++) begin
            if (c[0] ^ a[8*k+i]) c = (c >> 1) ^ 32'hEDB8_8320;
            else                 c = c >> 1;
         end
      for (int k = 0; k < 8; k++) ix[7-k] = c[k];
      return ix;
   endfunction

   function automatic logic [47:0] gen_addr(input int i);
      return {8'(i*29+3), 8'(i*13), 8'(i*7+1), 8'(i*5+9), 8'(i*3+i/4), 8'(i)};
   endfunction

   task automatic write_word(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      tbl_wr = 1'b1; tbl_sel = s; tbl_wdata = d;
      @(negedge clk);
      tbl_wr = 1'b0;
   endtask

   // Table with only the entry for ix set (or everything but it when inv)
   task automatic load_single(input logic [7:0] ix, input bit inv);
      for (int w = 0; w < 8; w++) begin
         logic [31:0] d;
         d = (w == ix[7:5]) ? (32'h8000_0000 >> ix[4:0]) : 32'h0;
         write_word(3'(w), inv ? ~d : d);
      end
   endtask

   task automatic send_addr(input logic [47:0] a, input int wr_at,
                            input logic [2:0] ws, input logic [31:0] wd,
                            output logic v, output logic [7:0] ix,
                            output logic acc, output logic v2);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         addr_vld = 1'b1; addr_first = (k == 0); addr_byte = a[8*k +: 8];
         if (k == wr_at) begin tbl_wr = 1'b1; tbl_sel = ws; tbl_wdata = wd; end
         else tbl_wr = 1'b0;
      end
      @(negedge clk);
      addr_vld = 1'b0; addr_first = 1'b0; tbl_wr = 1'b0;
      v = res_vld; ix = res_index; acc = res_accept;
      @(negedge clk);
      v2 = res_vld;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin
      logic        v, acc, v2;
      logic [7:0]  ix, eix;
      logic [47:0] a;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 / R8: reset contents
      for (int w = 0; w < 8; w++) begin
         tbl_sel = 3'(w);
         #1;
         chk(tbl_rdata == 32'h0, "R5 reset word", tbl_rdata, 0);
      end
      chk(res_vld == 1'b0, "R3 idle strobe", res_vld, 0);
      a = gen_addr(1);
      send_addr(a, -1, 0, 0, v, ix, acc, v2);
      chk(v == 1'b1, "R3 strobe", v, 1);
      chk(ix == exp_index(a), "R1 index", ix, exp_index(a));
      chk(acc == 1'b0, "R5 empty table rejects", acc, 0);

      // R8: word write and readback
      for (int w = 0; w < 8; w++) write_word(3'(w), 32'hA5C3_0000 ^ (w * 32'h0101_1357));
      for (int w = 0; w < 8; w++) begin
         @(negedge clk);
         tbl_sel = 3'(w);
         #1;
         chk(tbl_rdata == (32'hA5C3_0000 ^ (w * 32'h0101_1357)), "R8 readback",
             tbl_rdata, 32'hA5C3_0000 ^ (w * 32'h0101_1357));
      end

      // R1 R4 R6 sweep: single entry and complement table
      for (int i = 0; i < 48; i++) begin
         a = gen_addr(i);
         eix = exp_index(a);
         load_single(eix, 1'b0);
         send_addr(a, -1, 0, 0, v, ix, acc, v2);
         chk(v == 1'b1, "R3 strobe", v, 1);
         chk(v2 == 1'b0, "R3 single cycle", v2, 0);
         chk(ix == eix, "R1 index", ix, eix);
         chk(acc == a[0], "R4/R6 entry lookup", acc, a[0]);
         load_single(eix, 1'b1);
         send_addr(a, -1, 0, 0, v, ix, acc, v2);
         chk(acc == 1'b0, "R4 other entries ignored", acc, 0);
      end

      // R7: promiscuous override
      for (int w = 0; w < 8; w++) write_word(3'(w), 32'h0);
      promisc = 1'b1;
      a = gen_addr(4);
      send_addr(a, -1, 0, 0, v, ix, acc, v2);
      chk(acc == 1'b1, "R7 unicast promisc", acc, 1);
      a = gen_addr(5);
      send_addr(a, -1, 0, 0, v, ix, acc, v2);
      chk(acc == 1'b1, "R7 group promisc", acc, 1);
      promisc = 1'b0;

      // R2: abandoned partial address, then a full one
      a = gen_addr(7);
      eix = exp_index(a);
      load_single(eix, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         addr_vld = 1'b1; addr_first = (k == 0); addr_byte = 8'hF0 + 8'(k);
      end
      send_addr(a, -1, 0, 0, v, ix, acc, v2);
      chk(ix == eix, "R2 restart index", ix, eix);
      chk(acc == 1'b1, "R2 restart accept", acc, 1);
      // R2: stray bytes produce no result
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         addr_vld = 1'b1; addr_first = 1'b0; addr_byte = 8'(k * 17);
         #1;
         chk(res_vld == 1'b0, "R2 stray bytes", res_vld, 0);
      end
      @(negedge clk);
      addr_vld = 1'b0;
      #1;
      chk(res_vld == 1'b0, "R2 stray bytes", res_vld, 0);

      // R9: writes during a lookup apply to the next address
      a = gen_addr(9);
      eix = exp_index(a);
      for (int w = 0; w < 8; w++) write_word(3'(w), 32'h0);
      send_addr(a, 0, eix[7:5], 32'h8000_0000 >> eix[4:0], v, ix, acc, v2);
      chk(acc == 1'b0, "R9 write with first byte", acc, 0);
      send_addr(a, -1, 0, 0, v, ix, acc, v2);
      chk(acc == 1'b1, "R9 write seen next", acc, 1);
      send_addr(a, 3, eix[7:5], 32'h0, v, ix, acc, v2);
      chk(acc == 1'b1, "R9 clear mid address", acc, 1);
      send_addr(a, -1, 0, 0, v, ix, acc, v2);
      chk(acc == 1'b0, "R9 clear seen next", acc, 0);

      summary();
      $finish;
   end

endmodule